// File: doc/BRIEF.md
# ADC Sample Timing Sequencer

This block times the sample strobes for the front end of an analog-to-digital converter that accumulates several samples per conversion. Software programs one 8-bit control word with three fields: a start-up delay code, a gap-dither enable and a 4-bit inter-sample gap. A conversion request then runs a burst of samples. The block pulses `sample_start` once per sample, waits for the converter's `sample_done`, and inserts the programmed gap before the next sample. The sampling capacitor is open during the gap.

Some events leave the analog path unsettled: enabling the converter, switching the reference to its internal source, or a wake from deep sleep to measure. Each of these marks a start-up delay as owed. The next conversion then waits a power-of-two number of converter-clock cycles before its first sample. With dithering on, the gap field counts up by one after every sample and wraps from 15 to 0. This moves the sampling instant around and keeps periodic interference from lining up with it.

No data flows through this block, so it has no valid/ready stream. The strobes are plain pins. The converter applies back-pressure only through `sample_done`: the block never issues a new `sample_start` while a sample is outstanding, and it waits for as long as `sample_done` stays low.

Top module: `adc_sample_sequencer`

## Requirements
- R1: After reset the control word reads 0 and `sample_start` is low.
- R2: A write with `cfg_we` stores `cfg_wdata` whole, and `cfg_rdata` returns it. Bits [2:0] hold the start-up code, bit [3] the dither enable and bits [7:4] the gap. Codes 6 and 7 are stored and read back unchanged.
- R3: `conv_start` is accepted on a clock edge while the block is idle and `conv_enable` is high. The first `sample_start` is then high in the cycle after edge k+D, where k is the accepting edge. D is 0 unless a start-up delay is owed. If one is owed, codes 1 to 5 give 16, 32, 64, 128 and 256, and codes 0, 6 and 7 give 0.
- R4: A rising `conv_enable`, a rising `ref_internal` or a high `wake_meas` marks a start-up delay as owed. The next accepted conversion uses it and clears it. A falling `ref_internal` marks nothing.
- R5: Suppose `sample_done` is accepted at edge j and samples remain in the burst. The next `sample_start` is then high in the cycle after edge j+G, where G is the gap field as it stood at edge j.
- R6: With the dither bit set, each accepted `sample_done`, including the last one, adds one to the stored gap field modulo 16. The new value is visible on `cfg_rdata`.
- R7: A write on the same edge as an accepted `sample_done` wins over the dither increment.
- R8: A write during a running gap or start-up count does not change that count. It applies from the next delay on.
- R9: A conversion issues exactly `burst_len`+1 sample strobes and then returns to idle. `conv_start` has no effect while a conversion runs or while `conv_enable` is low.
- R10: A `sample_done` while no sample is outstanding is ignored. It changes neither the gap field nor the strobe output.
- R11: Dropping `conv_enable` abandons the conversion: no further `sample_start` appears.
- R12: `sample_start` is a one-cycle pulse, and no second pulse comes before `sample_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word write value |
| cfg_rdata | output | 8 | Current control word |
| conv_enable | input | 1 | Converter enable level |
| ref_internal | input | 1 | High when the internal reference is selected |
| wake_meas | input | 1 | Pulse: woken from deep sleep to measure |
| conv_start | input | 1 | Conversion request |
| burst_len | input | BURST_W | Number of samples minus one |
| sample_start | output | 1 | Pulse: open the sampling window |
| sample_done | input | 1 | Pulse from the converter: sample taken |

## Verification
Nearly all state in this block shows up as the number of cycles between a port event and the next `sample_start`. A wrong start-up flag or a wrong delay decode moves the first strobe of a conversion by 16 or more cycles. A corrupted gap counter moves the next strobe by the size of the error. A wrong dither step shows on `cfg_rdata` in the cycle right after the accepted `sample_done`, before any strobe depends on it. A miscounted burst shows as one missing or extra strobe within a gap of the expected end.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int INIT_CODE_W     = 3;
  localparam int GAP_W           = 4;
  localparam int INIT_BASE_SHIFT = 4;
  localparam int INIT_TOP_CODE   = 5;
  localparam int REG_W           = INIT_CODE_W + 1 + GAP_W;
  localparam int CNT_W           = INIT_BASE_SHIFT + INIT_TOP_CODE;

  // bits [7:4] gap, [3] dither enable, [2:0] start-up code
  typedef struct packed {
    logic [GAP_W-1:0]       gap;
    logic                   vary;
    logic [INIT_CODE_W-1:0] init_code;
  } seq_cfg_t;

  typedef enum logic [2:0] {
    SEQ_IDLE  = 3'd0,
    SEQ_INIT  = 3'd1,
    SEQ_ISSUE = 3'd2,
    SEQ_HOLD  = 3'd3,
    SEQ_GAP   = 3'd4
  } seq_state_t;

  // code 0 and codes above the top code give no delay
  function automatic logic [CNT_W-1:0] init_cycles(input logic [INIT_CODE_W-1:0] code);
    logic [CNT_W-1:0] res;
    res = '0;
    if (code != '0 && int'(code) <= INIT_TOP_CODE)
      res = CNT_W'(1) << (INIT_BASE_SHIFT + int'(code) - 1);
    return res;
  endfunction
endpackage

// File: rtl/adc_seq_cfg_reg.sv
module adc_seq_cfg_reg
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             step,
  output seq_cfg_t         cfg,
  output logic [REG_W-1:0] rd_data
);
  timeunit 1ns;
  timeprecision 1ps;

  seq_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q <= seq_cfg_t'(wr_data);
    end else if (step && cfg_q.vary) begin
      cfg_q.gap <= cfg_q.gap + 1'b1;
    end
  end

  assign cfg     = cfg_q;
  assign rd_data = cfg_q;

  // R7
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == $past(wr_data));

  // R6
  vary_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cfg_q.vary && !wr_en) |=> cfg_q.gap == GAP_W'($past(cfg_q.gap) + 1'b1));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !wr_en) |=> $stable(rd_data));
endmodule

// File: rtl/adc_seq_init_track.sv
module adc_seq_init_track (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_enable,
  input  logic ref_internal,
  input  logic wake_meas,
  input  logic consume,
  output logic pending_eff
);
  timeunit 1ns;
  timeprecision 1ps;

  logic en_q;
  logic ref_q;
  logic pend_q;
  logic trig;

  assign trig        = (conv_enable & ~en_q) | (ref_internal & ~ref_q) | wake_meas;
  assign pending_eff = pend_q | trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ref_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      en_q   <= conv_enable;
      ref_q  <= ref_internal;
      pend_q <= consume ? 1'b0 : pending_eff;
    end
  end

  // R4
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !consume) |=> pend_q);

  // R4
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> !pend_q);
endmodule

// File: rtl/adc_seq_delay_cnt.sv
module adc_seq_delay_cnt #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == CW'(1));

  // R8
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> cnt_q == CW'($past(cnt_q) - 1'b1));

  // R3
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val));
endmodule

// File: rtl/adc_sample_sequencer.sv
module adc_sample_sequencer
  import adc_seq_pkg::*;
#(
  parameter int BURST_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [REG_W-1:0]   cfg_wdata,
  output logic [REG_W-1:0]   cfg_rdata,
  input  logic               conv_enable,
  input  logic               ref_internal,
  input  logic               wake_meas,
  input  logic               conv_start,
  input  logic [BURST_W-1:0] burst_len,
  output logic               sample_start,
  input  logic               sample_done
);
  timeunit 1ns;
  timeprecision 1ps;

  seq_state_t         state_q, state_d;
  logic [BURST_W-1:0] rem_q, rem_d;
  seq_cfg_t           cfg;
  logic               pending_eff;
  logic               start_ok;
  logic               step;
  logic               cnt_load;
  logic [CNT_W-1:0]   cnt_val;
  logic               cnt_last;
  logic [CNT_W-1:0]   init_n;
  logic [CNT_W-1:0]   gap_n;

  assign start_ok = (state_q == SEQ_IDLE) && conv_start && conv_enable;
  assign step     = (state_q == SEQ_HOLD) && sample_done && conv_enable;
  assign init_n   = init_cycles(cfg.init_code);
  assign gap_n    = CNT_W'(cfg.gap);

  adc_seq_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_data (cfg_wdata),
    .step    (step),
    .cfg     (cfg),
    .rd_data (cfg_rdata)
  );

  adc_seq_init_track u_init (
    .clk          (clk),
    .rst_n        (rst_n),
    .conv_enable  (conv_enable),
    .ref_internal (ref_internal),
    .wake_meas    (wake_meas),
    .consume      (start_ok),
    .pending_eff  (pending_eff)
  );

  adc_seq_delay_cnt #(.CW(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .last     (cnt_last)
  );

  always_comb begin
    state_d  = state_q;
    rem_d    = rem_q;
    cnt_load = 1'b0;
    cnt_val  = init_n;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start_ok) begin
          rem_d = burst_len;
          if (pending_eff && init_n != '0) begin
            state_d  = SEQ_INIT;
            cnt_load = 1'b1;
          end else begin
            state_d = SEQ_ISSUE;
          end
        end
      end
      SEQ_INIT:  if (cnt_last) state_d = SEQ_ISSUE;
      SEQ_ISSUE: state_d = SEQ_HOLD;
      SEQ_HOLD: begin
        if (sample_done) begin
          if (rem_q == '0) begin
            state_d = SEQ_IDLE;
          end else begin
            rem_d = rem_q - 1'b1;
            if (gap_n != '0) begin
              state_d  = SEQ_GAP;
              cnt_load = 1'b1;
              cnt_val  = gap_n;
            end else begin
              state_d = SEQ_ISSUE;
            end
          end
        end
      end
      SEQ_GAP:   if (cnt_last) state_d = SEQ_ISSUE;
      default:   state_d = SEQ_IDLE;
    endcase
    if (!conv_enable) state_d = SEQ_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      rem_q   <= '0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
    end
  end

  assign sample_start = (state_q == SEQ_ISSUE);

  // R3
  zero_delay_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && !(pending_eff && init_n != '0)) |=> sample_start);

  // R12
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_start |=> !sample_start);

  // R11
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_enable |=> !sample_start);

  // R5
  zero_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && rem_q != '0 && cfg.gap == '0 && !cfg_we) |=> sample_start);

  // R10
  stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_done && state_q != SEQ_HOLD && !cfg_we) |=> $stable(cfg_rdata));

  // R9
  burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && rem_q == '0) |=> state_q == SEQ_IDLE);
endmodule

// File: tb/adc_sample_sequencer_test.sv
module adc_sample_sequencer_test;
  import adc_seq_pkg::*;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int BW = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [REG_W-1:0] cfg_wdata = '0;
  logic [REG_W-1:0] cfg_rdata;
  logic             conv_enable = 1'b0;
  logic             ref_internal = 1'b0;
  logic             wake_meas = 1'b0;
  logic             conv_start = 1'b0;
  logic [BW-1:0]    burst_len = '0;
  logic             sample_start;
  logic             sample_done = 1'b0;

  int checks = 0;
  int fails = 0;
  int m_code = 0;
  int m_vary = 0;
  int m_gap = 0;
  bit m_pend = 1'b0;

  always #2.5 clk = ~clk;

  adc_sample_sequencer #(.BURST_W(BW)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .conv_enable  (conv_enable),
    .ref_internal (ref_internal),
    .wake_meas    (wake_meas),
    .conv_start   (conv_start),
    .burst_len    (burst_len),
    .sample_start (sample_start),
    .sample_done  (sample_done)
  );

  function automatic int exp_init(int code);
    if (code >= 1 && code <= 5) return 16 << (code - 1);
    return 0;
  endfunction

  function automatic logic [7:0] pack_cfg(int code, int vary, int gap);
    return {4'(gap), 1'(vary), 3'(code)};
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_start(output int n, input int lim);
    n = 0;
    while (!sample_start && n < lim) begin
      cyc();
      n++;
    end
  endtask

  task automatic quiet(int cycles, string req, string what);
    bit seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      cyc();
      seen |= sample_start;
    end
    chk(!seen, req, what, int'(seen), 0);
  endtask

  task automatic write_cfg(int code, int vary, int gap);
    cfg_we = 1'b1;
    cfg_wdata = pack_cfg(code, vary, gap);
    cyc();
    cfg_we = 1'b0;
    m_code = code; m_vary = vary; m_gap = gap;
    chk(cfg_rdata == pack_cfg(code, vary, gap), "R2", "readback",
        int'(cfg_rdata), int'(pack_cfg(code, vary, gap)));
  endtask

  // wr_mode: 0 no write, 1 write at first done, 2 random writes at done
  task automatic run_conv(int n, bit inject, int wr_mode);
    int d;
    int e;
    int g_used;
    int lat;
    int new_gap;
    bit extra;
    bit do_wr;
    conv_start = 1'b1;
    burst_len = BW'(n - 1);
    cyc();
    conv_start = 1'b0;
    e = m_pend ? exp_init(m_code) : 0;
    m_pend = 1'b0;
    wait_start(d, 400);
    chk(d == e && sample_start, "R3", "cycles to first sample", d, e);
    for (int s = 0; s < n; s++) begin
      lat = $urandom_range(1, 3);
      extra = 1'b0;
      conv_start = inject;
      for (int c = 0; c < lat; c++) begin
        cyc();
        extra |= sample_start;
      end
      conv_start = 1'b0;
      chk(!extra, "R12", "strobe while sample outstanding", int'(extra), 0);
      do_wr = (wr_mode == 1 && s == 0) || (wr_mode == 2 && $urandom_range(0, 3) == 0);
      new_gap = $urandom_range(0, 15);
      g_used = m_gap;
      sample_done = 1'b1;
      if (do_wr) begin
        cfg_we = 1'b1;
        cfg_wdata = pack_cfg(m_code, m_vary, new_gap);
      end
      cyc();
      sample_done = 1'b0;
      cfg_we = 1'b0;
      if (do_wr) m_gap = new_gap;
      else if (m_vary != 0) m_gap = (m_gap + 1) % 16;
      chk(cfg_rdata == pack_cfg(m_code, m_vary, m_gap), do_wr ? "R7" : "R6",
          "control word after sample", int'(cfg_rdata), int'(pack_cfg(m_code, m_vary, m_gap)));
      if (s < n - 1) begin
        wait_start(d, 40);
        chk(d == g_used && sample_start, "R5", "gap before next sample", d, g_used);
      end else begin
        quiet(20, "R9", "strobe after burst end");
      end
    end
  endtask

  initial begin
    int d;
    void'($urandom(32'd2024));
    #1;
    chk(cfg_rdata == '0, "R1", "control word in reset", int'(cfg_rdata), 0);
    chk(sample_start == 1'b0, "R1", "strobe in reset", int'(sample_start), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    chk(cfg_rdata == '0, "R1", "control word after reset", int'(cfg_rdata), 0);

    conv_enable = 1'b1;
    m_pend = 1'b1;
    cyc();

    // R3 code 3 with start-up owed from enable
    write_cfg(3, 0, 0);
    run_conv(1, 1'b0, 0);
    // R4 nothing owed now
    run_conv(1, 1'b0, 0);
    // R4 wake pulse, longest code
    write_cfg(5, 0, 2);
    wake_meas = 1'b1; cyc(); wake_meas = 1'b0; m_pend = 1'b1;
    run_conv(2, 1'b0, 0);
    // R4 reference rise owes, fall does not
    ref_internal = 1'b1; cyc(); m_pend = 1'b1;
    write_cfg(1, 0, 0);
    run_conv(1, 1'b0, 0);
    ref_internal = 1'b0; cyc();
    run_conv(1, 1'b0, 0);
    // R3 reserved codes read back and give no delay
    write_cfg(7, 0, 0);
    wake_meas = 1'b1; cyc(); wake_meas = 1'b0; m_pend = 1'b1;
    run_conv(1, 1'b0, 0);
    write_cfg(6, 0, 1);
    wake_meas = 1'b1; cyc(); wake_meas = 1'b0; m_pend = 1'b1;
    run_conv(2, 1'b0, 0);
    // R6 wrap 14, 15, 0, 1
    write_cfg(0, 1, 14);
    run_conv(3, 1'b0, 0);
    chk(m_gap == 1, "R6", "model wrap", m_gap, 1);
    // R7 write beats increment, R9 start ignored while busy
    write_cfg(0, 1, 5);
    run_conv(3, 1'b1, 1);

    // R8 write during a running gap
    write_cfg(0, 0, 6);
    conv_start = 1'b1; burst_len = BW'(1); cyc(); conv_start = 1'b0;
    wait_start(d, 20);
    chk(d == 0, "R3", "no delay owed", d, 0);
    cyc();
    sample_done = 1'b1; cyc(); sample_done = 1'b0;
    cyc();
    cfg_we = 1'b1; cfg_wdata = pack_cfg(0, 0, 1); cyc(); cfg_we = 1'b0; m_gap = 1;
    wait_start(d, 40);
    chk(d + 2 == 6, "R8", "gap after mid-count write", d + 2, 6);
    cyc();
    sample_done = 1'b1; cyc(); sample_done = 1'b0;
    quiet(10, "R9", "strobe after burst end");

    // R10 stray done while idle
    write_cfg(0, 1, 3);
    sample_done = 1'b1; cyc(); sample_done = 1'b0;
    chk(cfg_rdata == pack_cfg(0, 1, 3), "R10", "gap after stray done",
        int'(cfg_rdata), int'(pack_cfg(0, 1, 3)));
    quiet(10, "R10", "strobe after stray done");

    // R11 abort during gap, R9 start while disabled
    write_cfg(0, 0, 10);
    conv_start = 1'b1; burst_len = BW'(1); cyc(); conv_start = 1'b0;
    wait_start(d, 20);
    chk(d == 0, "R3", "no delay owed", d, 0);
    cyc();
    sample_done = 1'b1; cyc(); sample_done = 1'b0;
    cyc(); cyc();
    conv_enable = 1'b0;
    quiet(30, "R11", "strobe after disable");
    conv_start = 1'b1; cyc(); conv_start = 1'b0;
    quiet(20, "R9", "start while disabled");
    conv_enable = 1'b1; cyc(); m_pend = 1'b1;

    // random mix
    for (int it = 0; it < 24; it++) begin
      int code = $urandom_range(0, 7);
      int vary = $urandom_range(0, 1);
      int gap = $urandom_range(0, 15);
      int trig = $urandom_range(0, 3);
      write_cfg(code, vary, gap);
      case (trig)
        1: begin wake_meas = 1'b1; cyc(); wake_meas = 1'b0; m_pend = 1'b1; end
        2: begin ref_internal = 1'b1; cyc(); ref_internal = 1'b0; m_pend = 1'b1; end
        3: begin conv_enable = 1'b0; cyc(); conv_enable = 1'b1; cyc(); m_pend = 1'b1; end
        default: ;
      endcase
      run_conv($urandom_range(1, 4), 1'($urandom_range(0, 1)), 2);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #750000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule